// File: doc/BRIEF.md
# Bidirectional Crosspoint Switch Fabric

This block is a switch fabric with P identical pins. Each pin can be set to act as an input or as an output, and any mix of the two is allowed. An output pin takes its data from one chosen input pin. Any number of outputs may share the same source, so one input can fan out to many outputs. The data path runs straight from pin to pin through logic only, with no registers, so every connection has the same delay.

Each pin has three separate vectors: a value read from the pin, a value driven onto it, and an enable for that drive. Because of this, no tristate logic is needed. Software sets up the fabric through a simple write port. One write changes exactly one pin's entry, which holds its direction, a connect flag and a source index. All other entries stay as they were. A read port returns the entry of any pin in the same cycle.

The whole connection table is also brought out on flat vectors. A wrapper can use these to build a larger fabric from a 2×2 tile of copies that behaves as one array of twice the size.

Top module: `xpoint_fabric`

## Requirements
- R1: After reset every pin is an input with its connect flag clear and source 0. All of `pin_oe` and `pin_out` read 0.
- R2: A write with `cfg_we` high updates only the entry of pin `cfg_pin`, at the next rising clock edge. The written values are direction (`cfg_dir`, 1 = output), connect flag (`cfg_link`) and source index (`cfg_src`). No other entry changes.
- R3: `rd_dir`, `rd_link` and `rd_src` show the entry of pin `rd_pin` in the same cycle, with no clock edge in between.
- R4: A pin makes a valid connection when it is an output, its connect flag is 1, its source differs from itself, and the source is an input. Such a pin drives `pin_oe`=1, and its `pin_out` follows `pin_in` of the source combinationally.
- R5: Several outputs may select the same source at once, and each of them carries that source's value.
- R6: A pin with no valid connection has `pin_oe`=0 and `pin_out`=0. This includes every input pin and every output whose connect flag is 0.
- R7: An output whose selected source is set as an output has no valid connection.
- R8: An output that selects itself as its source has no valid connection.
- R9: The `pin_in` value of a pin set as an output reaches no other pin's `pin_out`.
- R10: Rewriting one pin's entry leaves the `pin_oe` and `pin_out` of every other connected output unchanged.
- R11: `tbl_dir`, `tbl_link` and `tbl_src` present the full table. Pin k's source occupies bits [k*SW +: SW] of `tbl_src`, where SW = clog2(P).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration table |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_pin | input | SW | Index of the pin whose entry is written |
| cfg_dir | input | 1 | Direction to write, 1 = output |
| cfg_link | input | 1 | Connect flag to write |
| cfg_src | input | SW | Source pin index to write |
| rd_pin | input | SW | Index of the pin to read back |
| rd_dir | output | 1 | Direction of pin `rd_pin` |
| rd_link | output | 1 | Connect flag of pin `rd_pin` |
| rd_src | output | SW | Source index of pin `rd_pin` |
| pin_in | input | P | Value seen on each pin |
| pin_out | output | P | Value driven onto each pin |
| pin_oe | output | P | Drive enable for each pin |
| tbl_dir | output | P | Direction of every pin |
| tbl_link | output | P | Connect flag of every pin |
| tbl_src | output | P*SW | Source index of every pin, packed |

## Verification
A corrupted table entry is visible at once. In the cycle right after the bad write, the readback port and the flat table show it, and `pin_oe` on the affected pin shows it too. If a write spills into a neighbouring entry, a pin the write never addressed loses or changes its drive. Flaws in the validity logic show up with no clock at all: they appear as `pin_out` tracking a pin set as an output, or as drive enabled on a self-selected pin. So the bench compares all pins at every step, and it holds `pin_in` at patterns where the wrong source and the right source would differ.

// File: rtl/xpoint_fabric.sv
module xpoint_fabric #(
  parameter int P  = 8,
  parameter int SW = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_pin,
  input  logic            cfg_dir,
  input  logic            cfg_link,
  input  logic [SW-1:0]   cfg_src,
  input  logic [SW-1:0]   rd_pin,
  output logic            rd_dir,
  output logic            rd_link,
  output logic [SW-1:0]   rd_src,
  input  logic [P-1:0]    pin_in,
  output logic [P-1:0]    pin_out,
  output logic [P-1:0]    pin_oe,
  output logic [P-1:0]    tbl_dir,
  output logic [P-1:0]    tbl_link,
  output logic [P*SW-1:0] tbl_src
);

  logic [P-1:0]  dir_q;
  logic [P-1:0]  link_q;
  logic [SW-1:0] src_q [P];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      link_q <= '0;
      for (int k = 0; k < P; k++) src_q[k] <= '0;
    end else if (cfg_we) begin
      dir_q[cfg_pin]  <= cfg_dir;
      link_q[cfg_pin] <= cfg_link;
      src_q[cfg_pin]  <= cfg_src;
    end
  end

  assign rd_dir  = dir_q[rd_pin];
  assign rd_link = link_q[rd_pin];
  assign rd_src  = src_q[rd_pin];
  assign tbl_dir  = dir_q;
  assign tbl_link = link_q;

  for (genvar i = 0; i < P; i++) begin : g_pin
    logic valid;
    assign tbl_src[i*SW +: SW] = src_q[i];
    assign valid = dir_q[i] && link_q[i] && (src_q[i] != SW'(i)) && !dir_q[src_q[i]];
    assign pin_oe[i]  = valid;
    assign pin_out[i] = valid & pin_in[src_q[i]];

    assert_others_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_pin != SW'(i)) |=> $stable({dir_q[i], link_q[i], src_q[i]}));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_pin == SW'(i)) |=>
        (tbl_dir[i] == $past(cfg_dir) && tbl_link[i] == $past(cfg_link)
         && tbl_src[i*SW +: SW] == $past(cfg_src)));

    assert_source_not_driving_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[i] |-> !pin_oe[src_q[i]]);

    assert_idle_pin_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[i] |-> !pin_out[i]);
  end

  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && tbl_dir == '0 && tbl_link == '0));

endmodule

// File: tb/xpoint_fabric_test.sv
module xpoint_fabric_test;
  localparam int P = 8;
  localparam int SW = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_dir = 0, cfg_link = 0;
  logic [SW-1:0] cfg_pin = 0, cfg_src = 0, rd_pin = 0, rd_src;
  logic rd_dir, rd_link;
  logic [P-1:0] pin_in = 0, pin_out, pin_oe, tbl_dir, tbl_link;
  logic [P*SW-1:0] tbl_src;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  xpoint_fabric #(.P(P)) uut (.*);

  // {we, pin[2:0], dir, link, src[2:0], pin_in[7:0], exp_oe[7:0], exp_out[7:0]}
  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 3'd0, 1'b1, 1'b1, 3'd3, 8'h08, 8'h01, 8'h01},
    {1'b1, 3'd1, 1'b1, 1'b1, 3'd3, 8'h08, 8'h03, 8'h03},
    {1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 8'h00, 8'h03, 8'h00},
    {1'b1, 3'd2, 1'b1, 1'b1, 3'd5, 8'h20, 8'h07, 8'h04},
    {1'b1, 3'd2, 1'b1, 1'b1, 3'd0, 8'hFF, 8'h03, 8'h03},
    {1'b1, 3'd2, 1'b1, 1'b1, 3'd2, 8'hFF, 8'h03, 8'h03},
    {1'b1, 3'd2, 1'b1, 1'b0, 3'd5, 8'hFF, 8'h03, 8'h03},
    {1'b1, 3'd3, 1'b1, 1'b1, 3'd7, 8'h80, 8'h08, 8'h08},
    {1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 8'h08, 8'h03, 8'h03},
    {1'b1, 3'd7, 1'b1, 1'b1, 3'd6, 8'h40, 8'h83, 8'h80},
    {1'b1, 3'd4, 1'b1, 1'b1, 3'd6, 8'h48, 8'h93, 8'h93}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write(input logic [2:0] p, input logic d, input logic l, input logic [2:0] s);
    @(negedge clk);
    cfg_we = 1; cfg_pin = p; cfg_dir = d; cfg_link = l; cfg_src = s;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1 pin_in = 8'hFF;
    repeat (3) @(posedge clk);
    #2;
    check("R1 oe after reset", pin_oe, 0);
    check("R1 out after reset", pin_out, 0);
    check("R1 dir table", tbl_dir, 0);
    check("R1 link table", tbl_link, 0);
    check("R1 src table", tbl_src, 0);
    rst_n = 1;
    pin_in = 0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_we = VEC[v][32]; cfg_pin = VEC[v][31:29]; cfg_dir = VEC[v][28];
      cfg_link = VEC[v][27]; cfg_src = VEC[v][26:24]; pin_in = VEC[v][23:16];
      @(posedge clk); #1 cfg_we = 0;
      #1;
      check($sformatf("R4 R5 R6 R7 R8 R9 vector %0d oe", v), pin_oe, VEC[v][15:8]);
      check($sformatf("R4 R5 R6 R7 R8 R9 vector %0d out", v), pin_out, VEC[v][7:0]);
    end

    rd_pin = 3'd2; #1;
    check("R3 readback pin2", {rd_dir, rd_link, 1'b0, rd_src}, {1'b1, 1'b0, 1'b0, 3'd5});
    rd_pin = 3'd7; #1;
    check("R3 readback pin7", {rd_dir, rd_link, 1'b0, rd_src}, {1'b1, 1'b1, 1'b0, 3'd6});
    check("R11 src of pin4", tbl_src[4*SW +: SW], 3'd6);
    check("R11 dir table", tbl_dir, 8'h97);
    check("R11 link table", tbl_link, 8'h93);

    pin_in = 8'h48; #1;
    check("R4 combinational follow", pin_out, 8'h93);
    pin_in = 8'h08; #1;
    check("R4 combinational follow low", pin_out, 8'h03);

    pin_in = 8'h48;
    write(3'd4, 1'b1, 1'b1, 3'd5);
    #1;
    check("R10 other outputs hold oe", pin_oe, 8'h93);
    check("R10 other outputs hold out", pin_out, 8'h83);
    check("R2 only pin4 src changed", tbl_src,
          {3'd6, 3'd0, 3'd0, 3'd5, 3'd0, 3'd5, 3'd3, 3'd3});

    write(3'd5, 1'b1, 1'b0, 3'd1);
    pin_in = 8'hFF; #1;
    check("R9 output pin input ignored", pin_out[4], 1'b0);
    check("R7 source set as output", pin_oe[4], 1'b0);

    write(3'd6, 1'b1, 1'b1, 3'd6);
    #1;
    check("R8 self select", pin_oe[6], 1'b0);
    check("R7 downstream of self loop", pin_oe[7], 1'b0);

    @(negedge clk); rst_n = 0; #1;
    check("R1 reset clears oe", pin_oe, 0);
    check("R1 reset clears table", {tbl_dir, tbl_link}, 0);
    @(negedge clk); rst_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule